// File: doc/BRIEF.md
# Two-Branch Logic/Arithmetic Unit

This block is a purely combinational operand unit. It takes two equal-width operands and a two-bit operation code, and it returns one result of the same width plus a carry bit. The datapath has two parallel branches. The bitwise branch forms AND or OR. The arithmetic branch holds one ripple-carry adder that serves both addition and subtraction. For subtraction, the second operand is inverted on its way into the adder and the carry-in is forced to one.

A final two-way selector, steered by the upper code bit, decides which branch drives the result. The lower code bit picks the operation inside each branch. The result wraps modulo 2^WIDTH. The adder's top carry appears on its own port and never widens the result. The block has no clock and no reset, so the result follows the inputs within the same cycle. The instantiating logic registers the result where it needs to.

Top module: `dual_branch_alu`

## Requirements
- R1: Code 2'b00 (upper bit 0, lower bit 0) sets `result` to the bitwise AND of `opnd_a` and `opnd_b`.
- R2: Code 2'b01 sets `result` to the bitwise OR of `opnd_a` and `opnd_b`.
- R3: Code 2'b10 sets `result` to (`opnd_a` + `opnd_b`) mod 2^WIDTH.
- R4: Code 2'b11 sets `result` to (`opnd_a` - `opnd_b`) mod 2^WIDTH, formed as `opnd_a` + ~`opnd_b` + 1.
- R5: Under code 2'b10, `carry_out` equals bit WIDTH of the unbounded sum `opnd_a` + `opnd_b`.
- R6: Under code 2'b11, `carry_out` is 1 exactly when `opnd_a` >= `opnd_b` as unsigned values, which means no borrow occurred.
- R7: Whenever the upper code bit is 0 (codes 2'b00 and 2'b01), `carry_out` is 0 for every operand pair.
- R8: The block is combinational. `result` and `carry_out` take their new values from a change of operands or code with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand (minuend for subtraction) |
| opnd_b | input | WIDTH | Second operand (subtrahend for subtraction) |
| func_sel | input | 2 | Operation code: bit 1 picks the branch, bit 0 picks the operation within it |
| result | output | WIDTH | Selected branch output, wrapped to WIDTH bits |
| carry_out | output | 1 | Adder carry for arithmetic codes, 0 for bitwise codes |

## Verification
The bench builds two copies of the block. The first uses the default WIDTH of 8. It receives directed operand pairs: all-zero, all-one and sign-bit-only values, the three subtraction orderings (equal, smaller, larger), and a run of random pairs under each code. The second copy uses WIDTH=4, which reduces the input space to 1024 combinations. The bench sweeps every code and operand pair on it exhaustively, so every carry and borrow pattern through the ripple chain is observed at least once.

// File: rtl/dual_branch_alu_pkg.sv
package dual_branch_alu_pkg;

  // Operation codes: bit 1 chooses the branch, bit 0 the operation inside it.
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } alu_op_e;

  localparam int unsigned BRANCH_BIT  = 1;
  localparam int unsigned VARIANT_BIT = 0;

endpackage

// File: rtl/bitwise_branch.sv
module bitwise_branch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             use_or,
  output logic [WIDTH-1:0] res_out
);

  logic [WIDTH-1:0] and_bits;
  logic [WIDTH-1:0] or_bits;

  // One AND/OR cell per bit, with a local two-way pick.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_bits[i] = a_in[i] & b_in[i];
    assign or_bits[i]  = a_in[i] | b_in[i];
    assign res_out[i]  = use_or ? or_bits[i] : and_bits[i];
  end

  always_comb begin
    if (!$isunknown({a_in, b_in, use_or})) begin
      if (!use_or)
        AST_AND_SUBSET: assert (((res_out & ~a_in) | (res_out & ~b_in)) == '0); // R1
      else
        AST_OR_COVERS: assert (((res_out & a_in) == a_in) && ((res_out & b_in) == b_in)
                               && ((res_out & ~(a_in | b_in)) == '0)); // R2
    end
  end

endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             c_out
);

  always_comb begin
    logic cy;
    cy = c_in;
    for (int i = 0; i < WIDTH; i++) begin
      sum_out[i] = x_in[i] ^ y_in[i] ^ cy;
      cy         = (x_in[i] & y_in[i]) | (cy & (x_in[i] ^ y_in[i]));
    end
    c_out = cy;
  end

endmodule

// File: rtl/arith_branch.sv
module arith_branch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             do_sub,
  output logic [WIDTH-1:0] res_out,
  output logic             cy_out
);

  logic [WIDTH-1:0] b_eff;

  // Conditional inversion of the second operand, one XOR per bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_inv
    assign b_eff[i] = b_in[i] ^ do_sub;
  end

  ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .x_in    (a_in),
    .y_in    (b_eff),
    .c_in    (do_sub),
    .sum_out (res_out),
    .c_out   (cy_out)
  );

  always_comb begin
    if (!$isunknown({a_in, b_in, do_sub})) begin
      if (!do_sub)
        AST_ADD_EXACT: assert ({cy_out, res_out} == ({1'b0, a_in} + {1'b0, b_in})); // R3
      else
        AST_SUB_INVERSE: assert (WIDTH'(res_out + b_in) == a_in); // R4
    end
  end

endmodule

// File: rtl/branch_select.sv
module branch_select #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] lane0,
  input  logic [WIDTH-1:0] lane1,
  input  logic             pick1,
  output logic [WIDTH-1:0] sel_out
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_mux
    assign sel_out[i] = (lane1[i] & pick1) | (lane0[i] & ~pick1);
  end

endmodule

// File: rtl/dual_branch_alu.sv
module dual_branch_alu
  import dual_branch_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [1:0]       func_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  logic             branch_arith;
  logic             variant;
  logic [WIDTH-1:0] bit_res;
  logic [WIDTH-1:0] sum_res;
  logic             add_cy;

  assign branch_arith = func_sel[BRANCH_BIT];
  assign variant      = func_sel[VARIANT_BIT];

  bitwise_branch #(.WIDTH(WIDTH)) u_bitwise (
    .a_in    (opnd_a),
    .b_in    (opnd_b),
    .use_or  (variant),
    .res_out (bit_res)
  );

  arith_branch #(.WIDTH(WIDTH)) u_arith (
    .a_in    (opnd_a),
    .b_in    (opnd_b),
    .do_sub  (variant),
    .res_out (sum_res),
    .cy_out  (add_cy)
  );

  branch_select #(.WIDTH(WIDTH)) u_select (
    .lane0   (bit_res),
    .lane1   (sum_res),
    .pick1   (branch_arith),
    .sel_out (result)
  );

  assign carry_out = add_cy & branch_arith;

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, func_sel})) begin
      if (alu_op_e'(func_sel) == OP_SUB)
        AST_SUB_NO_BORROW: assert (carry_out == (opnd_a >= opnd_b)); // R6
      if (alu_op_e'(func_sel) == OP_ADD)
        AST_ADD_CARRY: assert (carry_out == (({1'b0, opnd_a} + {1'b0, opnd_b}) >> WIDTH)); // R5
      if (!branch_arith)
        AST_LOGIC_NO_CARRY: assert (carry_out == 1'b0); // R7
    end
  end

endmodule

// File: tb/dual_branch_alu_tb.sv
module dual_branch_alu_tb;

  localparam int unsigned W  = 8;
  localparam int unsigned W4 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0]  a, b;
  logic [1:0]    f;
  logic [W-1:0]  z;
  logic          co;

  logic [W4-1:0] a4, b4;
  logic [1:0]    f4;
  logic [W4-1:0] z4;
  logic          co4;

  int checks = 0;
  int errors = 0;

  dual_branch_alu #(.WIDTH(W)) u_dut (
    .opnd_a(a), .opnd_b(b), .func_sel(f), .result(z), .carry_out(co)
  );

  dual_branch_alu #(.WIDTH(W4)) u_dut_w4 (
    .opnd_a(a4), .opnd_b(b4), .func_sel(f4), .result(z4), .carry_out(co4)
  );

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic [1:0] op);
    case (op)
      2'b00:   model = {1'b0, x & y};
      2'b01:   model = {1'b0, x | y};
      2'b10:   model = {1'b0, x} + {1'b0, y};
      default: model = {(x >= y), W'(x - y)};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'b00:   tag_of = "R1";
      2'b01:   tag_of = "R2";
      2'b10:   tag_of = "R3";
      default: tag_of = "R4";
    endcase
  endfunction

  function automatic string cy_tag(input logic [1:0] op);
    case (op)
      2'b10:   cy_tag = "R5";
      2'b11:   cy_tag = "R6";
      default: cy_tag = "R7";
    endcase
  endfunction

  // Drive away from the edge, sample one time unit after the next edge.
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] op);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; f = op;
    @(posedge clk); #1;
    exp = model(x, y, op);
    checks++;
    if (z !== exp[W-1:0]) begin
      errors++;
      $display("FAIL %s result a=%h b=%h op=%b actual=%h expected=%h",
               tag_of(op), x, y, op, z, exp[W-1:0]);
    end
    checks++;
    if (co !== exp[W]) begin
      errors++;
      $display("FAIL %s carry a=%h b=%h op=%b actual=%b expected=%b",
               cy_tag(op), x, y, op, co, exp[W]);
    end
  endtask

  task automatic t_initial_state();
    // All-zero inputs give zero for every code (R1 R7).
    for (int op = 0; op < 4; op++) apply('0, '0, 2'(op));
  endtask

  task automatic t_example_vectors();
    apply(8'b1001_1101, 8'b1010_0110, 2'b00); // R1: expect 1000_0100
    apply(8'b0000_0011, 8'b1100_1000, 2'b01); // R2: expect 1100_1011
    apply(8'b0110_0110, 8'b0111_1000, 2'b10); // R3: expect 1101_1110
    apply(8'b1111_1101, 8'b1111_1101, 2'b11); // R4: equal operands give zero
  endtask

  task automatic t_corners();
    logic [W-1:0] v [3];
    v[0] = 8'h00; v[1] = 8'hFF; v[2] = 8'h80;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        for (int op = 0; op < 4; op++) apply(v[i], v[j], 2'(op));
  endtask

  task automatic t_sub_orderings();
    apply(8'h5A, 8'h5A, 2'b11); // R6: A == B, carry 1
    apply(8'h10, 8'h11, 2'b11); // R6: A < B, borrow, wraps to FF
    apply(8'h11, 8'h10, 2'b11); // R6: A > B, carry 1
    apply(8'h00, 8'h01, 2'b11); // R4 wrap
  endtask

  task automatic t_carry_gating();
    // Operands that would carry in the adder, under bitwise codes (R7).
    apply(8'hFF, 8'h01, 2'b00);
    apply(8'hFF, 8'hFF, 2'b01);
    apply(8'hFF, 8'h01, 2'b10); // R5: carry 1, result 00
  endtask

  task automatic t_comb_response();
    // R8: change inputs, no clock edge, result follows.
    @(negedge clk);
    a = 8'h0F; b = 8'hF0; f = 2'b01;
    #1;
    checks++;
    if (z !== 8'hFF) begin
      errors++;
      $display("FAIL R8 no-edge update actual=%h expected=%h", z, 8'hFF);
    end
    f = 2'b10; a = 8'h80; b = 8'h80;
    #1;
    checks++;
    if (z !== 8'h00 || co !== 1'b1) begin
      errors++;
      $display("FAIL R8 no-edge update actual=%b_%h expected=1_00", co, z);
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++)
      apply(W'($urandom), W'($urandom), 2'(n % 4));
  endtask

  task automatic t_exhaustive_w4();
    for (int op = 0; op < 4; op++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          logic [W4:0] exp;
          a4 = W4'(x); b4 = W4'(y); f4 = 2'(op);
          #1;
          case (op)
            0: exp = {1'b0, W4'(x & y)};
            1: exp = {1'b0, W4'(x | y)};
            2: exp = 5'(x + y);
            default: exp = {(x >= y), W4'(x - y)};
          endcase
          checks++;
          if ({co4, z4} !== exp) begin
            errors++;
            $display("FAIL %s w4 a=%0d b=%0d actual=%b_%h expected=%b_%h",
                     tag_of(2'(op)), x, y, co4, z4, exp[W4], exp[W4-1:0]);
          end
        end
  endtask

  initial begin
    a = '0; b = '0; f = '0;
    a4 = '0; b4 = '0; f4 = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_initial_state();
    t_example_vectors();
    t_corners();
    t_sub_orderings();
    t_carry_gating();
    t_comb_response();
    t_random();
    t_exhaustive_w4();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule